// File: doc/BRIEF.md
# Fixed-Priority Masked Interrupt Controller Core

This block collects eight level-sensitive interrupt request lines and turns them into a single interrupt signal for a processor. Each request line is passed through a two-flop synchronizer. It is then captured into a pending register, where it stays until it is granted. A software mask register decides which pending requests may take part in arbitration. Priority is fixed: line 0 wins over every other line and line 7 loses to all of them.

The processor answers the interrupt with a one-cycle acknowledge strobe. That strobe moves the winning line from the pending register into the in-service register. The processor ends the handler with a one-cycle end-of-interrupt strobe, which retires the highest-priority level still marked in service. While a level is in service, requests of equal or lower priority cannot raise the interrupt output. A request of higher priority can, so nesting is possible. The pending, in-service and mask registers are brought out as ports so that the surrounding logic can observe them.

Top module: `prio_irq_core`

## Requirements
- R1: Synchronous active-low reset clears the pending register, the in-service register, the synchronizer flops, `int_o` and `irq_id_o`, and sets every mask bit to 1.
- R2: A request line held high at the inputs sets its bit in `pend_o` on the third rising edge. The bit stays set until that line is granted.
- R3: When `mask_we_i` is high, `mask_wdata_i` is loaded into the mask register on the next edge. Mask bit n = 1 masks line n.
- R4: A masked line still sets its pending bit, but it never raises `int_o` and is never granted.
- R5: `int_o` is high exactly when some pending line is unmasked and the lowest-index such line has a strictly lower index than every set bit of `isr_o`.
- R6: `ack_i` high while `int_o` is high clears the winning bit in `pend_o` and sets it in `isr_o` on the same edge. `ack_i` while `int_o` is low changes nothing.
- R7: `eoi_i` clears only the lowest-index set bit of `isr_o` on the next edge. When `isr_o` is all zero, `eoi_i` has no effect.
- R8: A line that is still high after its grant sets its pending bit again on the following edge (level sensitivity).
- R9: `irq_id_o` gives the binary index (0 to 7) of the winning line while `int_o` is high, and is 0 while `int_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | 8 | Asynchronous level request lines, bit n = line n |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | New mask value |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| int_o | output | 1 | Interrupt request to the processor |
| irq_id_o | output | 3 | Index of the winning line |
| pend_o | output | 8 | Pending register |
| isr_o | output | 8 | In-service register |
| mask_o | output | 8 | Mask register |

## Verification
A request reaches `pend_o` three rising edges after the input rises. Mask writes, grants and end-of-interrupt take effect on the first edge after their strobe. `int_o` and `irq_id_o` are combinational from the registers, so they follow those registers in the same cycle. The bench drives inputs on falling edges and advances a cycle-accurate model of the registers on each rising edge. It compares every output at the next falling edge, so each result is checked in the exact cycle it is due. The directed checks are timed by counting the same edges.

// File: rtl/prio_irq_pkg.sv
// Package: shared defaults for the priority interrupt core.
// Assumes: line count stays a power of two no larger than 32.
package prio_irq_pkg;
    parameter int unsigned DEF_LINES  = 8;
    parameter int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/irq_sync_chain.sv
// Module: multi-stage synchronizer for a vector of asynchronous levels.
// Assumes: each bit is an independent level; no bus coherency needed.
module irq_sync_chain #(
    parameter int unsigned WIDTH  = prio_irq_pkg::DEF_LINES,
    parameter int unsigned STAGES = prio_irq_pkg::DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Purpose: first capture of the raw input levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            // Purpose: further metastability settling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_first_pick.sv
// Module: finds the lowest-index set bit of a vector (index 0 = highest priority).
// Assumes: purely combinational; index is 0 when no bit is set.
module irq_first_pick #(
    parameter int unsigned WIDTH = prio_irq_pkg::DEF_LINES,
    localparam int unsigned IDW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             valid_o,
    output logic [IDW-1:0]   idx_o,
    output logic [WIDTH-1:0] onehot_o
);
    // Purpose: scan from lowest priority up so the lowest index wins last.
    always_comb begin
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDW'(i);
        end
    end

    assign valid_o  = |vec_i;
    assign onehot_o = vec_i & (~vec_i + WIDTH'(1));
endmodule

// File: rtl/prio_irq_core.sv
// Module: fixed-priority masked interrupt core with pending, in-service and mask registers.
// Assumes: ack_i and eoi_i are single-cycle strobes synchronous to clk; request lines are async levels.
module prio_irq_core #(
    parameter int unsigned LINES  = prio_irq_pkg::DEF_LINES,
    parameter int unsigned STAGES = prio_irq_pkg::DEF_STAGES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LINES-1:0]         irq_req_i,
    input  logic                     mask_we_i,
    input  logic [LINES-1:0]         mask_wdata_i,
    input  logic                     ack_i,
    input  logic                     eoi_i,
    output logic                     int_o,
    output logic [$clog2(LINES)-1:0] irq_id_o,
    output logic [LINES-1:0]         pend_o,
    output logic [LINES-1:0]         isr_o,
    output logic [LINES-1:0]         mask_o
);
    localparam int unsigned IDW = $clog2(LINES);

    logic [LINES-1:0] req_sync;
    logic [LINES-1:0] pend_q, isr_q, mask_q;
    logic [LINES-1:0] cand_vec, win_oh, svc_oh, grant_vec, retire_vec;
    logic [IDW-1:0]   win_idx, svc_idx;
    logic             win_vld, svc_vld, int_raise;

    irq_sync_chain #(.WIDTH(LINES), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_req_i),
        .sync_o  (req_sync)
    );

    assign cand_vec = pend_q & ~mask_q;

    irq_first_pick #(.WIDTH(LINES)) u_win (
        .vec_i    (cand_vec),
        .valid_o  (win_vld),
        .idx_o    (win_idx),
        .onehot_o (win_oh)
    );

    irq_first_pick #(.WIDTH(LINES)) u_svc (
        .vec_i    (isr_q),
        .valid_o  (svc_vld),
        .idx_o    (svc_idx),
        .onehot_o (svc_oh)
    );

    // Purpose: raise the interrupt only when the winner outranks every level in service.
    always_comb begin
        int_raise  = win_vld && (!svc_vld || (win_idx < svc_idx));
        grant_vec  = (ack_i && int_raise) ? win_oh : '0;
        retire_vec = eoi_i ? svc_oh : '0;
    end

    // Purpose: capture requests and drop granted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | req_sync) & ~grant_vec;
    end

    // Purpose: track in-service levels, retire on end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~retire_vec) | grant_vec;
    end

    // Purpose: software mask register, all lines masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    assign int_o    = int_raise;
    assign irq_id_o = int_raise ? win_idx : '0;
    assign pend_o   = pend_q;
    assign isr_o    = isr_q;
    assign mask_o   = mask_q;
endmodule

// File: rtl/prio_irq_core_chk.sv
// Module: temporal checks for prio_irq_core, attached by bind.
// Assumes: observes ports only; LINES matches the bound instance.
module prio_irq_core_chk #(
    parameter int unsigned LINES = prio_irq_pkg::DEF_LINES
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ack_i,
    input logic                     eoi_i,
    input logic                     int_o,
    input logic [$clog2(LINES)-1:0] irq_id_o,
    input logic [LINES-1:0]         pend_o,
    input logic [LINES-1:0]         isr_o,
    input logic [LINES-1:0]         mask_o
);
    logic [LINES-1:0] gmask, upto_mask;

    // Purpose: bit of the line being granted now, and mask of levels at or above the winner.
    always_comb begin
        gmask     = (ack_i && int_o) ? (LINES'(1) << irq_id_o) : '0;
        upto_mask = (LINES'(2) << irq_id_o) - LINES'(1);
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_o == '1) && (isr_o == '0) && (pend_o == '0));

    // R2
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_o) & ~$past(gmask)) & ~pend_o) == '0));

    // R4
    masked_no_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> !mask_o[irq_id_o] && pend_o[irq_id_o]);

    // R5
    outrank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((isr_o & upto_mask) == '0));

    // R6
    ack_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o) |=> ((isr_o & ~$past(isr_o)) == $past(gmask)));

    // R7
    eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(ack_i && int_o) && (isr_o != '0)) |=>
            ($countones(isr_o) + 1 == $countones($past(isr_o))));

    // R9
    id_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_o |-> (irq_id_o == '0));
endmodule

bind prio_irq_core prio_irq_core_chk #(.LINES(LINES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_i    (ack_i),
    .eoi_i    (eoi_i),
    .int_o    (int_o),
    .irq_id_o (irq_id_o),
    .pend_o   (pend_o),
    .isr_o    (isr_o),
    .mask_o   (mask_o)
);

// File: tb/prio_irq_core_tb_top.sv
`timescale 1ns/1ps
module prio_irq_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_req_i, mask_wdata_i;
    logic       mask_we_i, ack_i, eoi_i;
    logic       int_o;
    logic [2:0] irq_id_o;
    logic [7:0] pend_o, isr_o, mask_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // model state
    logic [7:0] m_s1, m_s2, m_pend, m_isr, m_mask;

    always #2.5 clk = ~clk;

    prio_irq_core dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .mask_we_i(mask_we_i),
        .mask_wdata_i(mask_wdata_i), .ack_i(ack_i), .eoi_i(eoi_i), .int_o(int_o),
        .irq_id_o(irq_id_o), .pend_o(pend_o), .isr_o(isr_o), .mask_o(mask_o)
    );

    function automatic int first_one(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic exp_int();
        int w = first_one(m_pend & ~m_mask);
        return (w < 8) && (w < first_one(m_isr));
    endfunction

    function automatic logic [2:0] exp_id();
        return exp_int() ? 3'(first_one(m_pend & ~m_mask)) : 3'd0;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // advance the reference model by one rising edge
    task automatic model_step();
        logic [7:0] g, r;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_pend = '0; m_isr = '0; m_mask = '1;
        end else begin
            g = (ack_i && exp_int()) ? (8'd1 << first_one(m_pend & ~m_mask)) : 8'd0;
            r = (eoi_i && m_isr != 0) ? (8'd1 << first_one(m_isr)) : 8'd0;
            m_pend = (m_pend | m_s2) & ~g;
            m_isr  = (m_isr & ~r) | g;
            if (mask_we_i) m_mask = mask_wdata_i;
            m_s2 = m_s1;
            m_s1 = irq_req_i;
        end
    endtask

    task automatic compare_all();
        check("R2 pend",   pend_o, m_pend);
        check("R6 isr",    isr_o,  m_isr);
        check("R3 mask",   mask_o, m_mask);
        check("R5 int",    {7'd0, int_o}, {7'd0, exp_int()});
        check("R9 id",     {5'd0, irq_id_o}, {5'd0, exp_id()});
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        mask_we_i = 1'b0; ack_i = 1'b0; eoi_i = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; irq_req_i = '0; mask_we_i = 0; mask_wdata_i = '0; ack_i = 0; eoi_i = 0;
        @(negedge clk);
        run(3);
        // R1: reset values
        check("R1 mask", mask_o, 8'hFF);
        check("R1 pend", pend_o, 8'h00);
        check("R1 int",  {7'd0, int_o}, 8'h00);
        rst_n = 1'b1;

        // R4: line 3 masked, still pending, no interrupt
        irq_req_i = 8'h08;
        run(2);
        check("R2 not yet", pend_o, 8'h00);
        run(1);
        check("R2 third edge", pend_o, 8'h08);
        run(1);
        check("R4 masked int", {7'd0, int_o}, 8'h00);

        // R3: unmask line 3
        mask_we_i = 1'b1; mask_wdata_i = 8'hF7;
        cycle();
        check("R3 mask value", mask_o, 8'hF7);
        check("R3 int now", {7'd0, int_o}, 8'h01);
        check("R9 id three", {5'd0, irq_id_o}, 8'h03);

        // R6: grant line 3
        ack_i = 1'b1;
        cycle();
        check("R6 isr set", isr_o, 8'h08);
        check("R6 pend cleared", pend_o, 8'h00);
        cycle();
        check("R8 repend", pend_o, 8'h08);
        check("R5 blocked same level", {7'd0, int_o}, 8'h00);
        ack_i = 1'b1;
        cycle();
        check("R6 ack ignored", isr_o, 8'h08);

        // R5: higher level line 1 interrupts nested
        mask_we_i = 1'b1; mask_wdata_i = 8'hF5; irq_req_i = 8'h0A;
        run(4);
        check("R5 nest int", {7'd0, int_o}, 8'h01);
        check("R9 id one", {5'd0, irq_id_o}, 8'h01);
        ack_i = 1'b1;
        cycle();
        check("R6 nested isr", isr_o, 8'h0A);

        // R7: retire lowest index first
        irq_req_i = 8'h00;
        eoi_i = 1'b1;
        cycle();
        check("R7 first eoi", isr_o, 8'h08);
        eoi_i = 1'b1;
        cycle();
        check("R7 second eoi", isr_o, 8'h00);
        mask_we_i = 1'b1; mask_wdata_i = 8'hFF;
        cycle();
        eoi_i = 1'b1;
        cycle();
        check("R7 empty eoi", isr_o, 8'h00);

        // random phase
        mask_wdata_i = 8'h00; mask_we_i = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 4 == 0) irq_req_i = 8'($urandom & $urandom);
            ack_i = ($urandom % 3 == 0);
            eoi_i = ($urandom % 4 == 0);
            if ($urandom % 16 == 0) begin
                mask_we_i = 1'b1; mask_wdata_i = 8'($urandom & $urandom);
            end
            rst_n = (k != 2000);
            cycle();
        end
        rst_n = 1'b1;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule